// File: doc/BRIEF.md
# Dual Receive Buffer Controller

This block sits behind a frame assembly stage. Each time the assembly stage finishes a frame, it presents one strobe. With the strobe come the identifier, the frame type, the remote-request flag, the length code, eight data bytes, a per-filter identifier match vector, each filter's frame-type bit and an error-abort flag. The controller qualifies the match results against each buffer's operating mode. It then picks at most one of two receive buffers, writes the whole message into that buffer, and sets the buffer's full flag. While a full flag is set, that buffer is locked against new loads until the host releases it.

Buffer 0 has priority and is served by the low filters (0 and 1). Buffer 1 is served by filters 2 to 5. When rollover is enabled, a message that buffer 0 accepts but cannot hold moves into buffer 1, provided buffer 1 is empty. In this case buffer 1's own filters play no part. When a message is dropped because its target is full, a sticky overflow flag is set. A byte-wide register port holds the configuration, the flags and the buffer contents. Two interrupt lines and a last-load report complete the block.

Top module: `rx_buf_ctrl`

## Requirements
- R1: After reset, both full flags, both overflow flags, both interrupt lines, the rollover enable, both interrupt enables and both 2-bit modes are 0. The last-buffer report is 0.
- R2: A message with at least one qualified match among filters 0 and 1 loads buffer 0 if buffer 0 is empty. The stored hit code is the lowest qualified filter number (0 or 1).
- R3: If buffer 0 does not take the message and rollover does not apply, a qualified match among filters 2 to 5 loads buffer 1 when it is empty. The code is the lowest qualified filter number. At most one buffer is loaded per message, and buffer 0 wins when both qualify.
- R4: A load overwrites every stored field whatever the frame type or length code. Reading offset k of buffer b at address 16*(b+1)+k returns the following. Offset 0 is {000, ext, rtr, code[2:0]}. Offsets 1 to 4 are identifier bits 7:0, 15:8, 23:16 and 28:24. Offset 5 is the length code in bits 3:0. Offsets 6 to 13 are data bytes 0 to 7, where byte j is data bits 8j+7:8j. Offsets 14 and 15 read 0.
- R5: Loading a buffer sets its full flag. While the flag is set, that buffer's contents do not change. Writing 1 to bit b of address 1 clears full flag b.
- R6: With rollover on (control bit 4), a message that buffer 0 accepts while buffer 0 is full loads buffer 1 if buffer 1 is empty. It carries buffer 0's filter code, and buffer 1's filters are ignored. If buffer 1 is also full, the overflow flag of buffer 1 is set.
- R7: In mode 00, a filter match counts only when that filter's frame-type bit equals the frame's extended flag.
- R8: In mode 01, only standard frames through filters whose type bit is 0 count. In mode 10, only extended frames through filters whose type bit is 1 count.
- R9: In mode 11, the buffer accepts every message with code 7, including frames flagged as aborted. In modes 00 to 10, an aborted frame is never loaded and sets no flag.
- R10: Interrupt line b is high exactly when full flag b and interrupt enable b (control bit 5+b) are both set.
- R11: A message dropped because its target buffer is full sets that buffer's overflow flag, which stays set until 1 is written to bit 2+b of address 1. A message that buffer 0 accepts while full, with rollover off and no buffer-1 acceptance, sets overflow 0.
- R12: The last-buffer output, and bit 4 of address 1, give the buffer most recently loaded. The last-code output gives that load's hit code.
- R13: Address 0 reads and writes the control byte: mode of buffer 0 in bits 1:0, mode of buffer 1 in bits 3:2, rollover in bit 4, interrupt enables in bits 6:5. Address 1 reads {000, last, ovf1, ovf0, full1, full0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | One-cycle strobe: a finished frame is presented |
| msg_abort_i | input | 1 | Frame was cut short by an error |
| msg_ext_i | input | 1 | Frame uses the extended identifier |
| msg_rtr_i | input | 1 | Frame is a remote request |
| msg_id_i | input | 29 | Identifier |
| msg_dlc_i | input | 4 | Length code |
| msg_data_i | input | 64 | Data bytes, byte j in bits 8j+7:8j |
| filt_hit_i | input | 6 | Identifier match result per filter |
| filt_ext_i | input | 6 | Frame-type bit per filter |
| host_we_i | input | 1 | Register write strobe |
| host_addr_i | input | 6 | Register address |
| host_wdata_i | input | 8 | Register write data |
| host_rdata_o | output | 8 | Register read data (combinational) |
| full_o | output | 2 | Full flag per buffer |
| irq_o | output | 2 | Interrupt per buffer |
| last_buf_o | output | 1 | Buffer loaded most recently |
| last_code_o | output | 3 | Hit code of the most recent load |

## Verification
The assertions assume that a message strobe and a flag-clearing write never fall in the same cycle. They also assume that the abort flag and the match vectors are meaningful only while the strobe is high. The bench drives messages and host writes in separate cycles from separate tasks. Its random part draws match vectors, type bits, abort and mode settings freely, because every combination of those is legal input to the block.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int ID_W     = 29;
  localparam int DLC_W    = 4;
  localparam int NBYTES   = 8;
  localparam int CODE_W   = 3;
  localparam int NBUF     = 2;
  localparam logic [CODE_W-1:0] CODE_OPEN = '1;

  typedef enum logic [1:0] {
    MODE_FILT = 2'b00,
    MODE_STD  = 2'b01,
    MODE_EXT  = 2'b10,
    MODE_OPEN = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic                  ext;
    logic                  rtr;
    logic [DLC_W-1:0]      dlc;
    logic [ID_W-1:0]       id;
    logic [8*NBYTES-1:0]   data;
  } rx_msg_t;
endpackage

// File: rtl/rxb_qual.sv
module rxb_qual
  import rxb_pkg::*;
#(
  parameter int NUM_FILT = 6,
  parameter int B0_FILT  = 2
) (
  input  logic [NUM_FILT-1:0] filt_hit_i,
  input  logic [NUM_FILT-1:0] filt_ext_i,
  input  logic                msg_ext_i,
  input  rx_mode_e            mode0_i,
  input  rx_mode_e            mode1_i,
  output logic [NUM_FILT-1:0] qual_o
);
  for (genvar i = 0; i < NUM_FILT; i++) begin : g_f
    rx_mode_e m;
    logic     ok;
    if (i < B0_FILT) begin : g_b0
      assign m = mode0_i;
    end else begin : g_b1
      assign m = mode1_i;
    end
    always_comb begin
      case (m)
        MODE_FILT: ok = (filt_ext_i[i] == msg_ext_i);
        MODE_STD:  ok = !msg_ext_i && !filt_ext_i[i];
        MODE_EXT:  ok = msg_ext_i && filt_ext_i[i];
        default:   ok = 1'b0;  // open mode bypasses filters
      endcase
    end
    assign qual_o[i] = filt_hit_i[i] & ok;
  end
endmodule

// File: rtl/rxb_route.sv
module rxb_route
  import rxb_pkg::*;
#(
  parameter int NUM_FILT = 6,
  parameter int B0_FILT  = 2
) (
  input  logic                   valid_i,
  input  logic                   abort_i,
  input  logic [NUM_FILT-1:0]    qual_i,
  input  rx_mode_e               mode0_i,
  input  rx_mode_e               mode1_i,
  input  logic                   roll_i,
  input  logic [NBUF-1:0]        full_i,
  output logic [NBUF-1:0]        ld_o,
  output logic [NBUF-1:0]        ovf_set_o,
  output logic [CODE_W-1:0]      code0_o,
  output logic [CODE_W-1:0]      code1_o
);
  logic open0, open1, hit0, hit1, acc0, acc1;
  logic [CODE_W-1:0] idx0, idx1, c0, c1;

  assign open0 = (mode0_i == MODE_OPEN);
  assign open1 = (mode1_i == MODE_OPEN);
  assign hit0  = |qual_i[B0_FILT-1:0];
  assign hit1  = |qual_i[NUM_FILT-1:B0_FILT];
  assign acc0  = valid_i && (open0 || (!abort_i && hit0));
  assign acc1  = valid_i && (open1 || (!abort_i && hit1));

  // lowest-numbered qualified filter wins
  always_comb begin
    idx0 = '0;
    idx1 = CODE_W'(B0_FILT);
    for (int i = B0_FILT - 1; i >= 0; i--)
      if (qual_i[i]) idx0 = CODE_W'(i);
    for (int i = NUM_FILT - 1; i >= B0_FILT; i--)
      if (qual_i[i]) idx1 = CODE_W'(i);
  end

  assign c0 = open0 ? CODE_OPEN : idx0;
  assign c1 = open1 ? CODE_OPEN : idx1;

  always_comb begin
    ld_o      = '0;
    ovf_set_o = '0;
    code0_o   = c0;
    code1_o   = c1;
    if (acc0 && !full_i[0]) begin
      ld_o[0] = 1'b1;
    end else if (acc0 && roll_i) begin
      code1_o = c0;
      if (!full_i[1]) ld_o[1] = 1'b1;
      else            ovf_set_o[1] = 1'b1;
    end else if (acc1) begin
      if (!full_i[1]) ld_o[1] = 1'b1;
      else            ovf_set_o[1] = 1'b1;
    end else if (acc0) begin
      ovf_set_o[0] = 1'b1;
    end
  end
endmodule

// File: rtl/rxb_slot.sv
module rxb_slot
  import rxb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  rx_msg_t           msg_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_full_i,
  input  logic              set_ovf_i,
  input  logic              clr_ovf_i,
  input  logic [3:0]        rd_sel_i,
  output logic              full_o,
  output logic              ovf_o,
  output logic [7:0]        rd_byte_o
);
  localparam int ID_PAD = 32 - ID_W;

  rx_msg_t           msg_q;
  logic [CODE_W-1:0] code_q;
  logic              full_q, ovf_q;
  logic [31:0]       id_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q  <= '0;
      code_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      full_q <= (full_q & ~clr_full_i) | ld_i;
      ovf_q  <= (ovf_q & ~clr_ovf_i) | set_ovf_i;
      if (ld_i) begin
        msg_q  <= msg_i;
        code_q <= code_i;
      end
    end
  end

  assign id_w = {{ID_PAD{1'b0}}, msg_q.id};

  always_comb begin
    int k;
    k = int'(rd_sel_i);
    rd_byte_o = '0;
    if (k == 0) begin
      rd_byte_o[CODE_W-1:0] = code_q;
      rd_byte_o[CODE_W]     = msg_q.rtr;
      rd_byte_o[CODE_W+1]   = msg_q.ext;
    end else if (k <= 4) begin
      rd_byte_o = id_w[8*(k-1) +: 8];
    end else if (k == 5) begin
      rd_byte_o[DLC_W-1:0] = msg_q.dlc;
    end else if (k < 6 + NBYTES) begin
      rd_byte_o = msg_q.data[8*(k-6) +: 8];
    end
  end

  assign full_o = full_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/rx_buf_ctrl.sv
module rx_buf_ctrl
  import rxb_pkg::*;
#(
  parameter int NUM_FILT = 6,
  parameter int B0_FILT  = 2,
  parameter int ADDR_W   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     msg_valid_i,
  input  logic                     msg_abort_i,
  input  logic                     msg_ext_i,
  input  logic                     msg_rtr_i,
  input  logic [ID_W-1:0]          msg_id_i,
  input  logic [DLC_W-1:0]         msg_dlc_i,
  input  logic [8*NBYTES-1:0]      msg_data_i,
  input  logic [NUM_FILT-1:0]      filt_hit_i,
  input  logic [NUM_FILT-1:0]      filt_ext_i,
  input  logic                     host_we_i,
  input  logic [ADDR_W-1:0]        host_addr_i,
  input  logic [7:0]               host_wdata_i,
  output logic [7:0]               host_rdata_o,
  output logic [NBUF-1:0]          full_o,
  output logic [NBUF-1:0]          irq_o,
  output logic                     last_buf_o,
  output logic [CODE_W-1:0]        last_code_o
);
  localparam int REGION_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(1);

  rx_mode_e          mode0_q, mode1_q;
  logic              roll_q;
  logic [NBUF-1:0]   ie_q;
  logic              last_buf_q;
  logic [CODE_W-1:0] last_code_q;

  logic [NUM_FILT-1:0] qual;
  logic [NBUF-1:0]     ld, ovf_set, full_q, ovf_q, clr_full, clr_ovf;
  logic [CODE_W-1:0]   code0, code1;
  logic [NBUF-1:0][CODE_W-1:0] code;
  logic [NBUF-1:0][7:0]        slot_byte;
  logic ctrl_wr, flag_wr;
  logic [REGION_W-1:0] region;
  rx_msg_t msg;

  assign msg = '{ext: msg_ext_i, rtr: msg_rtr_i, dlc: msg_dlc_i,
                 id: msg_id_i, data: msg_data_i};

  assign ctrl_wr = host_we_i && (host_addr_i == CTRL_ADDR);
  assign flag_wr = host_we_i && (host_addr_i == FLAG_ADDR);
  assign region  = host_addr_i[ADDR_W-1:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode0_q <= MODE_FILT;
      mode1_q <= MODE_FILT;
      roll_q  <= 1'b0;
      ie_q    <= '0;
    end else if (ctrl_wr) begin
      mode0_q <= rx_mode_e'(host_wdata_i[1:0]);
      mode1_q <= rx_mode_e'(host_wdata_i[3:2]);
      roll_q  <= host_wdata_i[4];
      ie_q    <= host_wdata_i[6:5];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_buf_q  <= 1'b0;
      last_code_q <= '0;
    end else if (ld[0]) begin
      last_buf_q  <= 1'b0;
      last_code_q <= code0;
    end else if (ld[1]) begin
      last_buf_q  <= 1'b1;
      last_code_q <= code1;
    end
  end

  rxb_qual #(.NUM_FILT(NUM_FILT), .B0_FILT(B0_FILT)) u_qual (
    .filt_hit_i (filt_hit_i),
    .filt_ext_i (filt_ext_i),
    .msg_ext_i  (msg_ext_i),
    .mode0_i    (mode0_q),
    .mode1_i    (mode1_q),
    .qual_o     (qual)
  );

  rxb_route #(.NUM_FILT(NUM_FILT), .B0_FILT(B0_FILT)) u_route (
    .valid_i   (msg_valid_i),
    .abort_i   (msg_abort_i),
    .qual_i    (qual),
    .mode0_i   (mode0_q),
    .mode1_i   (mode1_q),
    .roll_i    (roll_q),
    .full_i    (full_q),
    .ld_o      (ld),
    .ovf_set_o (ovf_set),
    .code0_o   (code0),
    .code1_o   (code1)
  );

  assign code[0] = code0;
  assign code[1] = code1;

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    assign clr_full[b] = flag_wr && host_wdata_i[b];
    assign clr_ovf[b]  = flag_wr && host_wdata_i[NBUF+b];
    rxb_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_i       (ld[b]),
      .msg_i      (msg),
      .code_i     (code[b]),
      .clr_full_i (clr_full[b]),
      .set_ovf_i  (ovf_set[b]),
      .clr_ovf_i  (clr_ovf[b]),
      .rd_sel_i   (host_addr_i[3:0]),
      .full_o     (full_q[b]),
      .ovf_o      (ovf_q[b]),
      .rd_byte_o  (slot_byte[b])
    );
    assign irq_o[b] = full_q[b] & ie_q[b];
  end

  always_comb begin
    host_rdata_o = '0;
    if (host_addr_i == CTRL_ADDR) begin
      host_rdata_o = {1'b0, ie_q, roll_q, mode1_q, mode0_q};
    end else if (host_addr_i == FLAG_ADDR) begin
      host_rdata_o = {3'b000, last_buf_q, ovf_q, full_q};
    end else begin
      for (int b = 0; b < NBUF; b++)
        if (region == REGION_W'(b + 1)) host_rdata_o = slot_byte[b];
    end
  end

  assign full_o      = full_q;
  assign last_buf_o  = last_buf_q;
  assign last_code_o = last_code_q;
endmodule

// File: rtl/rx_buf_ctrl_chk.sv
module rx_buf_ctrl_chk
  import rxb_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       msg_valid_i,
  input logic       msg_abort_i,
  input logic [1:0] full_o,
  input logic [1:0] irq_o,
  input logic [1:0] ovf_q,
  input logic [1:0] ld,
  input logic [1:0] clr_full,
  input rx_mode_e   mode0_q,
  input rx_mode_e   mode1_q,
  input logic       last_buf_o
);
  // R3
  one_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld));

  // R5
  full_hold0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o[0] && !clr_full[0]) |=> full_o[0]);

  // R5
  full_hold1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o[1] && !clr_full[1]) |=> full_o[1]);

  // R5
  full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o[0]) |-> $past(ld[0]));

  // R10
  irq_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~full_o) == 2'b00));

  // R11
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf_q[0]) || $rose(ovf_q[1])) |-> $past(msg_valid_i));

  // R9
  abort_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_abort_i && mode0_q != MODE_OPEN && mode1_q != MODE_OPEN)
      |-> (ld == 2'b00));

  // R12
  last_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last_buf_o) |-> $past(|ld));
endmodule

bind rx_buf_ctrl rx_buf_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_valid_i (msg_valid_i),
  .msg_abort_i (msg_abort_i),
  .full_o      (full_o),
  .irq_o       (irq_o),
  .ovf_q       (ovf_q),
  .ld          (ld),
  .clr_full    (clr_full),
  .mode0_q     (mode0_q),
  .mode1_q     (mode1_q),
  .last_buf_o  (last_buf_o)
);

// File: tb/tb_rx_buf_ctrl.sv
module tb_rx_buf_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_valid_i = 0, msg_abort_i = 0, msg_ext_i = 0, msg_rtr_i = 0;
  logic [28:0] msg_id_i = '0;
  logic [3:0]  msg_dlc_i = '0;
  logic [63:0] msg_data_i = '0;
  logic [5:0]  filt_hit_i = '0, filt_ext_i = '0;
  logic        host_we_i = 0;
  logic [5:0]  host_addr_i = '0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;
  logic [1:0]  full_o, irq_o;
  logic        last_buf_o;
  logic [2:0]  last_code_o;

  int tests = 0, fails = 0;

  // expected model state
  bit          e_ext [2], e_rtr [2], ef [2], eo [2];
  logic [2:0]  e_code [2];
  logic [28:0] e_id [2];
  logic [3:0]  e_dlc [2];
  logic [63:0] e_data [2];
  bit          elast;
  logic [2:0]  ecode_last;
  logic [1:0]  cm0, cm1;
  bit          croll, cie0, cie1;

  always #5 clk = ~clk;

  rx_buf_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .msg_valid_i(msg_valid_i), .msg_abort_i(msg_abort_i),
    .msg_ext_i(msg_ext_i), .msg_rtr_i(msg_rtr_i), .msg_id_i(msg_id_i),
    .msg_dlc_i(msg_dlc_i), .msg_data_i(msg_data_i),
    .filt_hit_i(filt_hit_i), .filt_ext_i(filt_ext_i),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .full_o(full_o), .irq_o(irq_o),
    .last_buf_o(last_buf_o), .last_code_o(last_code_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr_i = a;
    #1 d = host_rdata_o;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we_i = 1; host_addr_i = a; host_wdata_i = d;
    if (a == 0) begin
      cm0 = d[1:0]; cm1 = d[3:2]; croll = d[4]; cie0 = d[5]; cie1 = d[6];
    end else if (a == 1) begin
      for (int b = 0; b < 2; b++) begin
        if (d[b])   ef[b] = 0;
        if (d[2+b]) eo[b] = 0;
      end
    end
    @(negedge clk);
    host_we_i = 0;
  endtask

  function automatic bit qualifies(int i, bit ext, logic [5:0] hit, logic [5:0] fx);
    logic [1:0] m;
    m = (i < 2) ? cm0 : cm1;
    if (!hit[i]) return 0;
    case (m)
      2'b00:   return fx[i] == ext;
      2'b01:   return !ext && !fx[i];
      2'b10:   return ext && fx[i];
      default: return 0;
    endcase
  endfunction

  task automatic send(input bit ext, rtr, input logic [28:0] id, input logic [3:0] dlc,
                      input logic [63:0] data, input logic [5:0] hit, fx,
                      input bit abort, output int tgt);
    bit q [6];
    bit a0, a1;
    logic [2:0] c0, c1, code;
    for (int i = 0; i < 6; i++) q[i] = qualifies(i, ext, hit, fx);
    a0 = (cm0 == 3) || (!abort && (q[0] || q[1]));
    a1 = (cm1 == 3) || (!abort && (q[2] || q[3] || q[4] || q[5]));
    c0 = (cm0 == 3) ? 3'd7 : (q[0] ? 3'd0 : 3'd1);
    c1 = 3'd7;
    if (cm1 != 3)
      for (int i = 5; i >= 2; i--) if (q[i]) c1 = 3'(i);
    tgt = -1; code = 0;
    if (a0 && !ef[0]) begin tgt = 0; code = c0; end
    else if (a0 && croll) begin
      if (!ef[1]) begin tgt = 1; code = c0; end else eo[1] = 1;
    end else if (a1) begin
      if (!ef[1]) begin tgt = 1; code = c1; end else eo[1] = 1;
    end else if (a0) eo[0] = 1;
    if (tgt >= 0) begin
      e_ext[tgt] = ext; e_rtr[tgt] = rtr; e_id[tgt] = id; e_dlc[tgt] = dlc;
      e_data[tgt] = data; e_code[tgt] = code; ef[tgt] = 1;
      elast = tgt[0]; ecode_last = code;
    end
    @(negedge clk);
    msg_valid_i = 1; msg_abort_i = abort; msg_ext_i = ext; msg_rtr_i = rtr;
    msg_id_i = id; msg_dlc_i = dlc; msg_data_i = data;
    filt_hit_i = hit; filt_ext_i = fx;
    @(negedge clk);
    msg_valid_i = 0; msg_abort_i = 0;
  endtask

  function automatic logic [7:0] exp_byte(int b, int k);
    logic [31:0] id32;
    id32 = {3'b000, e_id[b]};
    if (k == 0) return {3'b000, e_ext[b], e_rtr[b], e_code[b]};
    if (k <= 4) return id32[8*(k-1) +: 8];
    if (k == 5) return {4'b0000, e_dlc[b]};
    if (k <= 13) return e_data[b][8*(k-6) +: 8];
    return 8'h00;
  endfunction

  task automatic check_buf(int b, string req);
    logic [7:0] d;
    for (int k = 0; k < 16; k++) begin
      rd(6'(16*(b+1) + k), d);
      chk($sformatf("%s buf%0d byte%0d", req, b, k), d, exp_byte(b, k));
    end
  endtask

  task automatic check_flags(string req);
    logic [7:0] d;
    rd(6'd1, d);
    chk({req, " flags R13"}, d, {3'b000, elast, eo[1], eo[0], ef[1], ef[0]});
    chk({req, " full_o R5"}, full_o, {ef[1], ef[0]});
    chk({req, " irq_o R10"}, irq_o, {ef[1] & cie1, ef[0] & cie0});
    chk({req, " last_buf R12"}, last_buf_o, elast);
    chk({req, " last_code R12"}, last_code_o, ecode_last);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t;
    void'($urandom(32'h5eed_1234));
    cm0 = 0; cm1 = 0; croll = 0; cie0 = 0; cie1 = 0; elast = 0; ecode_last = 0;
    for (int b = 0; b < 2; b++) begin
      e_ext[b] = 0; e_rtr[b] = 0; ef[b] = 0; eo[b] = 0; e_code[b] = 0;
      e_id[b] = 0; e_dlc[b] = 0; e_data[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    check_flags("R1");
    rd(6'd0, d); chk("R1 ctrl", d, 8'h00);
    check_buf(0, "R1");

    // R13 control readback
    wr(6'd0, 8'h60);
    rd(6'd0, d); chk("R13 ctrl readback", d, 8'h60);

    // R2 buffer 0, filters 0 and 1 both hit -> code 0
    send(0, 1, 29'h000_05A5, 4'd2, 64'h8877_6655_4433_2211, 6'b000011, 6'b0, 0, t);
    chk("R2 target", t, 0);
    check_flags("R2"); check_buf(0, "R2 R4");

    // R11 buffer 0 full, no rollover, no buffer-1 match -> overflow 0
    send(1, 0, 29'h1ABC_DEF0, 4'd8, 64'hFFEE_DDCC_BBAA_9988, 6'b000010, 6'b000010, 0, t);
    chk("R11 dropped", t, -1);
    check_flags("R11"); check_buf(0, "R5 held");

    // R3 buffer 1 via filters 3 and 5 -> code 3
    send(1, 1, 29'h0123_4567, 4'd0, 64'h0102_0304_0506_0708, 6'b101000, 6'b101000, 0, t);
    chk("R3 target", t, 1);
    check_flags("R3"); check_buf(1, "R3 R4");

    // R5 clear all flags
    wr(6'd1, 8'h0F);
    check_flags("R5 cleared");

    // R3 priority: filters 1 and 2 both qualify -> buffer 0, code 1
    send(0, 0, 29'h0000_0111, 4'd1, 64'h0, 6'b000110, 6'b0, 0, t);
    chk("R3 priority target", t, 0);
    check_flags("R3 priority"); check_buf(0, "R3");

    // R6 rollover into buffer 1 with buffer-0 code
    wr(6'd0, 8'h70);
    send(0, 0, 29'h0000_0222, 4'd3, 64'hABCD, 6'b000001, 6'b0, 0, t);
    chk("R6 rollover target", t, 1);
    check_flags("R6"); check_buf(1, "R6");
    send(0, 0, 29'h0000_0333, 4'd3, 64'h1234, 6'b000001, 6'b0, 0, t);
    chk("R6 both full", t, -1);
    check_flags("R6 R11 ovf1");
    wr(6'd1, 8'h0F);

    // R7 mode 00: type mismatch is ignored
    wr(6'd0, 8'h60);
    send(1, 0, 29'h1000_0000, 4'd4, 64'h5555, 6'b111111, 6'b0, 0, t);
    chk("R7 type mismatch", t, -1);
    check_flags("R7"); check_buf(0, "R7 untouched");

    // R8 mode 01 rejects ext filter; mode 10 accepts ext frame on ext filter
    wr(6'd0, 8'h65);
    send(0, 0, 29'h0000_0444, 4'd5, 64'h6666, 6'b111111, 6'b111111, 0, t);
    chk("R8 std mode ext filter", t, -1);
    check_flags("R8 std");
    wr(6'd0, 8'h6A);
    send(1, 0, 29'h0ACE_0444, 4'd5, 64'h7777, 6'b000010, 6'b000010, 0, t);
    chk("R8 ext mode", t, 0);
    check_flags("R8 ext"); check_buf(0, "R8");
    wr(6'd1, 8'h0F);

    // R9 aborted frame dropped in filter mode, loaded in open mode
    wr(6'd0, 8'h60);
    send(0, 0, 29'h0000_0555, 4'd6, 64'h8888, 6'b111111, 6'b0, 1, t);
    chk("R9 abort dropped", t, -1);
    check_flags("R9 abort");
    wr(6'd0, 8'h6C);
    send(1, 1, 29'h1FFF_FFFF, 4'd15, 64'hDEAD_BEEF_CAFE_F00D, 6'b0, 6'b0, 1, t);
    chk("R9 open loads", t, 1);
    check_flags("R9 open"); check_buf(1, "R9");
    wr(6'd1, 8'h0F);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) wr(6'd0, 8'($urandom % 128));
      else if (r < 5) wr(6'd1, 8'($urandom % 16));
      send(1'($urandom), 1'($urandom), 29'($urandom), 4'($urandom),
           {$urandom, $urandom}, 6'($urandom), 6'($urandom),
           ($urandom % 8) == 0, t);
      check_flags("R5 R11 random");
      if (t >= 0) check_buf(t, "R4 random");
      if (n % 50 == 49) begin
        check_buf(0, "R4 sweep");
        check_buf(1, "R4 sweep");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule